// File: doc/BRIEF.md
# Per-Core Supply and Clock Operating-Point Controller

This block sits in every processor tile and decides the operating point of the local core: which supply rail feeds it (high, low, or none at all to cut leakage) and the frequency code sent to the tile's local oscillator. The requested point comes from one of three places, picked by a mode input: a static configuration word, a software-written word, or a built-in hardware policy. The hardware policy watches how full the core's input FIFO is and how often the core stalls. Once per fixed window it turns these into a load sample, smooths the samples with a first-order shift-based filter, and compares the result against a pair of hysteresis thresholds. A run of empty windows powers the core down.

Rail changes go through a sequencer so that the core supply is never disturbed while it is clocked. The oscillator is stopped first. The power-gate segments of the old rail are then released one per cycle, and the segments of the new rail are closed one per cycle. Only after that does the oscillator restart. The sequencer states are RUN (steady; oscillator enabled when a rail is connected), HALT (one cycle with the oscillator stopped), DROP (old-rail segments released), RAISE (new-rail segments closed) and RESUME (one cycle that commits the new rail). The transitions are: RUN→HALT when the request differs from the present rail; HALT→DROP when a rail is connected, HALT→RAISE when none is; DROP→RAISE when the last old segment is released and the target is a rail, DROP→RESUME when the target is disconnected; RAISE→RESUME when the last new segment closes; RESUME→RUN.

Top module: `core_power_ctrl`

## Requirements
- R1: During and straight after reset the rail state is disconnected (code 0), no gate segment is enabled, the oscillator enable is low, busy is low and the filtered load is 0.
- R2: Mode code 1 selects the software rail and frequency, code 2 the hardware policy, and codes 0 and 3 the static configuration; rail code 1 is the low rail, 2 the high rail, and 0 or 3 means disconnected.
- R3: From disconnected to a rail, busy stays high for SEG_COUNT+2 cycles, during which the new rail's segment count grows by at most one per cycle, and the sequence ends with all of that rail's segments enabled.
- R4: Between the two rails, busy stays high for 2*SEG_COUNT+2 cycles: every old segment is released before any new one is enabled, and the oscillator enable stays low for the whole time busy is high.
- R5: From a rail to disconnected, busy stays high for SEG_COUNT+2 cycles; afterwards no segment is enabled and the oscillator enable stays low.
- R6: High-rail and low-rail segments are never enabled in the same cycle.
- R7: While steady on a rail, the oscillator enable is high and the frequency output follows the selected source's frequency code one cycle after it changes.
- R8: A request that changes while a sequence runs does not alter that sequence or the rail it commits; the new request is served by a separate sequence that starts after the first completes.
- R9: A window in which the core stalled for at least half the window's cycles contributes half the FIFO level (rounded down) as its load sample; otherwise the sample is the FIFO level at the window's last cycle.
- R10: The filtered load changes only once per WIN_LEN cycles, by the signed difference (sample − filtered load) shifted right arithmetically by FILT_SHIFT.
- R11: In hardware mode a filtered load above the upper threshold asks for the high rail, one below the lower threshold asks for the low rail, and one in between keeps the previous request.
- R12: In hardware mode IDLE_WIN consecutive windows with a zero sample ask for disconnection, and the first nonzero sample afterwards asks for the low rail unless the filtered load is above the upper threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock, always on |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Source of the operating point (0/3 static, 1 software, 2 hardware) |
| static_rail | input | 2 | Rail code from static configuration |
| static_freq | input | FREQ_W | Frequency code from static configuration |
| sw_rail | input | 2 | Rail code written by software |
| sw_freq | input | FREQ_W | Frequency code written by software |
| fifo_level | input | LOAD_W | Input FIFO utilization, 0 empty to all ones full |
| core_stall | input | 1 | High in every cycle the core is stalled |
| thr_hi | input | LOAD_W | Upper threshold of the hardware policy |
| thr_lo | input | LOAD_W | Lower threshold of the hardware policy |
| hw_freq_hi | input | FREQ_W | Frequency code used with the high rail in hardware mode |
| hw_freq_lo | input | FREQ_W | Frequency code used with the low rail in hardware mode |
| osc_run | output | 1 | Oscillator enable |
| osc_freq | output | FREQ_W | Oscillator frequency code |
| gate_hi | output | SEG_COUNT | Enables of the high-rail power-gate segments |
| gate_lo | output | SEG_COUNT | Enables of the low-rail power-gate segments |
| rail_state | output | 2 | Rail now committed (0 off, 1 low, 2 high) |
| busy | output | 1 | High while a rail change is in progress |
| load_avg | output | LOAD_W | Filtered load of the hardware policy |

## Verification
The bench builds the block with SEG_COUNT = 8, WIN_LEN = 16, IDLE_WIN = 3, FILT_SHIFT = 3, LOAD_W = 8 and FREQ_W = 6. Short gate chains make every rail change finish in 10 or 18 cycles, so the exact duration of each change can be scored. A 16-cycle window lets the filter climb past the upper threshold, settle inside the hysteresis band, fall under the stall-halved sample and decay through an idle run into power-down within a few hundred cycles. A mid-sequence request change and the unused mode and rail codes are also driven.

// File: rtl/cpc_pkg.sv
`timescale 1ns/1ps
package cpc_pkg;

    typedef enum logic [1:0] {
        RAIL_OFF  = 2'd0,
        RAIL_LOW  = 2'd1,
        RAIL_HIGH = 2'd2
    } rail_e;

    typedef enum logic [2:0] {
        SQ_RUN,
        SQ_HALT,
        SQ_DROP,
        SQ_RAISE,
        SQ_RESUME
    } seq_e;

    function automatic rail_e decode_rail(input logic [1:0] code);
        case (code)
            2'd1:    return RAIL_LOW;
            2'd2:    return RAIL_HIGH;
            default: return RAIL_OFF;
        endcase
    endfunction

endpackage

// File: rtl/cpc_load_filter.sv
`timescale 1ns/1ps
module cpc_load_filter #(
    parameter int WIN_LEN    = 256,
    parameter int LOAD_W     = 8,
    parameter int FILT_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOAD_W-1:0] fifo_level,
    input  logic              core_stall,
    output logic              sample_valid,
    output logic [LOAD_W-1:0] sample,
    output logic [LOAD_W-1:0] load_avg
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);

    logic [CNT_W-1:0]        win_cnt;
    logic [CNT_W-1:0]        stall_cnt;
    logic [CNT_W-1:0]        stall_total;
    logic                    win_end;
    logic                    heavy;
    logic [LOAD_W-1:0]       x_now;
    logic signed [LOAD_W:0]  diff;
    logic signed [LOAD_W:0]  step;

    always_comb begin
        win_end     = (win_cnt == CNT_W'(WIN_LEN - 1));
        stall_total = stall_cnt + CNT_W'(core_stall);
        // stalled for half the window or more: demand is overstated
        heavy       = ({1'b0, stall_total} << 1) >= (CNT_W+1)'(WIN_LEN);
        x_now       = heavy ? (fifo_level >> 1) : fifo_level;
        diff        = $signed({1'b0, x_now}) - $signed({1'b0, load_avg});
        step        = diff >>> FILT_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt      <= '0;
            stall_cnt    <= '0;
            sample_valid <= 1'b0;
            sample       <= '0;
            load_avg     <= '0;
        end else begin
            sample_valid <= win_end;
            if (win_end) begin
                win_cnt   <= '0;
                stall_cnt <= '0;
                sample    <= x_now;
                load_avg  <= load_avg + step[LOAD_W-1:0];
            end else begin
                win_cnt   <= win_cnt + 1'b1;
                stall_cnt <= stall_total;
            end
        end
    end

endmodule

// File: rtl/cpc_hw_policy.sv
`timescale 1ns/1ps
module cpc_hw_policy
    import cpc_pkg::*;
#(
    parameter int LOAD_W   = 8,
    parameter int IDLE_WIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [LOAD_W-1:0] sample,
    input  logic [LOAD_W-1:0] load_avg,
    input  logic [LOAD_W-1:0] thr_hi,
    input  logic [LOAD_W-1:0] thr_lo,
    output rail_e             hw_rail
);
    localparam int IDLE_W = $clog2(IDLE_WIN + 1);

    logic [IDLE_W-1:0] idle_cnt;
    logic [IDLE_W-1:0] idle_next;

    always_comb begin
        if (sample != '0)
            idle_next = '0;
        else if (idle_cnt == IDLE_W'(IDLE_WIN))
            idle_next = idle_cnt;
        else
            idle_next = idle_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            hw_rail  <= RAIL_LOW;
        end else if (sample_valid) begin
            idle_cnt <= idle_next;
            if (idle_next == IDLE_W'(IDLE_WIN))
                hw_rail <= RAIL_OFF;
            else if (load_avg > thr_hi)
                hw_rail <= RAIL_HIGH;
            else if (load_avg < thr_lo)
                hw_rail <= RAIL_LOW;
            else if (hw_rail == RAIL_OFF)
                hw_rail <= RAIL_LOW;
        end
    end

endmodule

// File: rtl/cpc_rail_seq.sv
`timescale 1ns/1ps
module cpc_rail_seq
    import cpc_pkg::*;
#(
    parameter int SEG_COUNT = 48,
    parameter int FREQ_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rail_e                req_rail,
    input  logic [FREQ_W-1:0]    req_freq,
    output logic                 osc_run,
    output logic [FREQ_W-1:0]    osc_freq,
    output logic [SEG_COUNT-1:0] gate_hi,
    output logic [SEG_COUNT-1:0] gate_lo,
    output rail_e                rail_state,
    output logic                 busy
);
    seq_e                 state, state_nx;
    rail_e                cur_rail, tgt_rail;
    logic [FREQ_W-1:0]    freq_q;
    logic [SEG_COUNT-1:0] old_g, new_g;

    always_comb begin
        old_g = (cur_rail == RAIL_HIGH) ? gate_hi : gate_lo;
        new_g = (tgt_rail == RAIL_HIGH) ? gate_hi : gate_lo;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_RUN:    if (req_rail != cur_rail) state_nx = SQ_HALT;
            SQ_HALT:   state_nx = (cur_rail == RAIL_OFF) ? SQ_RAISE : SQ_DROP;
            SQ_DROP:   if (old_g[SEG_COUNT-1:1] == '0)
                           state_nx = (tgt_rail == RAIL_OFF) ? SQ_RESUME : SQ_RAISE;
            SQ_RAISE:  if (new_g[SEG_COUNT-2]) state_nx = SQ_RESUME;
            SQ_RESUME: state_nx = SQ_RUN;
            default:   state_nx = SQ_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_RUN;
        else        state <= state_nx;
    end

    // output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_rail <= RAIL_OFF;
            tgt_rail <= RAIL_OFF;
            freq_q   <= '0;
            gate_hi  <= '0;
            gate_lo  <= '0;
        end else begin
            unique case (state)
                SQ_RUN: begin
                    freq_q <= req_freq;
                    if (req_rail != cur_rail) tgt_rail <= req_rail;
                end
                SQ_HALT: ;
                SQ_DROP: begin
                    if (cur_rail == RAIL_HIGH) gate_hi <= gate_hi >> 1;
                    else                       gate_lo <= gate_lo >> 1;
                end
                SQ_RAISE: begin
                    if (tgt_rail == RAIL_HIGH) gate_hi <= {gate_hi[SEG_COUNT-2:0], 1'b1};
                    else                       gate_lo <= {gate_lo[SEG_COUNT-2:0], 1'b1};
                end
                SQ_RESUME: begin
                    cur_rail <= tgt_rail;
                    freq_q   <= req_freq;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy       = (state != SQ_RUN);
        osc_run    = (state == SQ_RUN) && (cur_rail != RAIL_OFF);
        osc_freq   = freq_q;
        rail_state = cur_rail;
    end

endmodule

// File: rtl/core_power_ctrl.sv
`timescale 1ns/1ps
module core_power_ctrl
    import cpc_pkg::*;
#(
    parameter int SEG_COUNT  = 48,
    parameter int WIN_LEN    = 256,
    parameter int IDLE_WIN   = 16,
    parameter int FILT_SHIFT = 3,
    parameter int LOAD_W     = 8,
    parameter int FREQ_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_sel,
    input  logic [1:0]           static_rail,
    input  logic [FREQ_W-1:0]    static_freq,
    input  logic [1:0]           sw_rail,
    input  logic [FREQ_W-1:0]    sw_freq,
    input  logic [LOAD_W-1:0]    fifo_level,
    input  logic                 core_stall,
    input  logic [LOAD_W-1:0]    thr_hi,
    input  logic [LOAD_W-1:0]    thr_lo,
    input  logic [FREQ_W-1:0]    hw_freq_hi,
    input  logic [FREQ_W-1:0]    hw_freq_lo,
    output logic                 osc_run,
    output logic [FREQ_W-1:0]    osc_freq,
    output logic [SEG_COUNT-1:0] gate_hi,
    output logic [SEG_COUNT-1:0] gate_lo,
    output logic [1:0]           rail_state,
    output logic                 busy,
    output logic [LOAD_W-1:0]    load_avg
);
    logic              smp_valid;
    logic [LOAD_W-1:0] smp;
    rail_e             hw_rail;
    rail_e             req_rail;
    logic [FREQ_W-1:0] req_freq;
    rail_e             cur_rail;

    cpc_load_filter #(
        .WIN_LEN(WIN_LEN), .LOAD_W(LOAD_W), .FILT_SHIFT(FILT_SHIFT)
    ) u_filter (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .core_stall(core_stall),
        .sample_valid(smp_valid), .sample(smp), .load_avg(load_avg)
    );

    cpc_hw_policy #(
        .LOAD_W(LOAD_W), .IDLE_WIN(IDLE_WIN)
    ) u_policy (
        .clk(clk), .rst_n(rst_n), .sample_valid(smp_valid), .sample(smp),
        .load_avg(load_avg), .thr_hi(thr_hi), .thr_lo(thr_lo), .hw_rail(hw_rail)
    );

    // source selection
    always_comb begin
        unique case (mode_sel)
            2'd1: begin
                req_rail = decode_rail(sw_rail);
                req_freq = sw_freq;
            end
            2'd2: begin
                req_rail = hw_rail;
                req_freq = (hw_rail == RAIL_HIGH) ? hw_freq_hi : hw_freq_lo;
            end
            default: begin
                req_rail = decode_rail(static_rail);
                req_freq = static_freq;
            end
        endcase
    end

    cpc_rail_seq #(
        .SEG_COUNT(SEG_COUNT), .FREQ_W(FREQ_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_rail(req_rail), .req_freq(req_freq),
        .osc_run(osc_run), .osc_freq(osc_freq), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .rail_state(cur_rail), .busy(busy)
    );

    assign rail_state = cur_rail;

endmodule

// File: rtl/cpc_checker.sv
`timescale 1ns/1ps
module cpc_checker #(
    parameter int SEG_COUNT = 48
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 osc_run,
    input logic [SEG_COUNT-1:0] gate_hi,
    input logic [SEG_COUNT-1:0] gate_lo,
    input logic [1:0]           rail_state
);

    a_r6_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((|gate_hi) && (|gate_lo)));

    a_r4_osc_halted_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !osc_run);

    a_r3_hi_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gate_hi) <= $countones($past(gate_hi)) + 1) &&
        ($countones(gate_hi) + 1 >= $countones($past(gate_hi))));

    a_r3_lo_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gate_lo) <= $countones($past(gate_lo)) + 1) &&
        ($countones(gate_lo) + 1 >= $countones($past(gate_lo))));

    a_r3_gates_move_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(gate_hi) || !$stable(gate_lo)) |-> busy);

    a_r7_powered_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rail_state != 2'd0) |-> osc_run);

    a_r8_rail_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rail_state));

endmodule

bind core_power_ctrl cpc_checker #(.SEG_COUNT(SEG_COUNT)) u_cpc_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .osc_run(osc_run),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .rail_state(rail_state)
);

// File: tb/core_power_ctrl_test.sv
`timescale 1ns/1ps
module core_power_ctrl_test;
    localparam int SEG  = 8;
    localparam int WIN  = 16;
    localparam int IDLE = 3;
    localparam int FW   = 6;
    localparam int LW   = 8;
    localparam logic [SEG-1:0] ALL = '1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [1:0]    mode_sel, static_rail, sw_rail;
    logic [FW-1:0] static_freq, sw_freq, hw_freq_hi, hw_freq_lo;
    logic [LW-1:0] fifo_level, thr_hi, thr_lo;
    logic          core_stall;
    logic          osc_run, busy;
    logic [FW-1:0] osc_freq;
    logic [SEG-1:0] gate_hi, gate_lo;
    logic [1:0]    rail_state;
    logic [LW-1:0] load_avg;

    core_power_ctrl #(
        .SEG_COUNT(SEG), .WIN_LEN(WIN), .IDLE_WIN(IDLE), .FILT_SHIFT(3),
        .LOAD_W(LW), .FREQ_W(FW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .static_rail(static_rail),
        .static_freq(static_freq), .sw_rail(sw_rail), .sw_freq(sw_freq),
        .fifo_level(fifo_level), .core_stall(core_stall), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .hw_freq_hi(hw_freq_hi), .hw_freq_lo(hw_freq_lo), .osc_run(osc_run),
        .osc_freq(osc_freq), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .rail_state(rail_state), .busy(busy), .load_avg(load_avg)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int    exp_rail_q[$];
    int    exp_dur_q[$];
    string exp_tag_q[$];
    int    exp_avg_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_seq(input int rail, input int dur, input string tag);
        exp_rail_q.push_back(rail);
        exp_dur_q.push_back(dur);
        exp_tag_q.push_back(tag);
    endtask

    task automatic settle();
        while (exp_rail_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // reference filter model: R9, R10
    initial begin
        int pos = 0, sacc = 0, tot, x, y = 0, d;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                pos = 0; sacc = 0; y = 0;
            end else begin
                tot = sacc + int'(core_stall);
                if (pos == WIN - 1) begin
                    x = (2 * tot >= WIN) ? int'(fifo_level) / 2 : int'(fifo_level);
                    d = x - y;
                    y = y + (d >>> 3);
                    exp_avg_q.push_back(y);
                    pos = 0; sacc = 0;
                end else begin
                    sacc = tot;
                    pos++;
                end
            end
        end
    end

    // monitor: scores each finished rail change and each filter update
    initial begin
        int bcnt = 0;
        bit osc_bad = 0, excl_bad = 0;
        int er, ed, ah, al, eh, el;
        string tg;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (busy) begin
                    bcnt++;
                    if (osc_run) osc_bad = 1;
                end
                if ((|gate_hi) && (|gate_lo)) excl_bad = 1;
                if (!busy && bcnt > 0) begin
                    if (exp_rail_q.size() == 0) begin
                        check(0, "R8 unexpected rail change", int'(rail_state), -1);
                    end else begin
                        er = exp_rail_q.pop_front();
                        ed = exp_dur_q.pop_front();
                        tg = exp_tag_q.pop_front();
                        eh = (er == 2) ? int'(ALL) : 0;
                        el = (er == 1) ? int'(ALL) : 0;
                        ah = int'(gate_hi);
                        al = int'(gate_lo);
                        check(int'(rail_state) == er, {tg, " rail"}, int'(rail_state), er);
                        check(bcnt == ed, {tg, " busy cycles"}, bcnt, ed);
                        check(ah == eh && al == el, {tg, " gate pattern hi"}, ah, eh);
                        check(!osc_bad, "R4 oscillator halted while busy", int'(osc_bad), 0);
                        check(!excl_bad, "R6 rails exclusive", int'(excl_bad), 0);
                    end
                    bcnt = 0; osc_bad = 0; excl_bad = 0;
                end
                while (exp_avg_q.size() > 0) begin
                    er = exp_avg_q.pop_front();
                    check(int'(load_avg) == er, "R10 filtered load", int'(load_avg), er);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_sel = 0; static_rail = 0; static_freq = 10;
        sw_rail = 0; sw_freq = 0; hw_freq_hi = 50; hw_freq_lo = 5;
        fifo_level = 0; core_stall = 0; thr_hi = 100; thr_lo = 40;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rail_state == 2'd0, "R1 rail at reset", int'(rail_state), 0);
        check(gate_hi == '0 && gate_lo == '0, "R1 gates at reset", int'(gate_hi | gate_lo), 0);
        check(!osc_run && !busy, "R1 osc/busy at reset", int'({osc_run, busy}), 0);
        check(load_avg == '0, "R1 load at reset", int'(load_avg), 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && rail_state == 2'd0, "R1 idle after reset", int'(busy), 0);

        // R3 static: off -> low
        expect_seq(1, SEG + 2, "R3 off to low");
        static_rail = 2'd1;
        settle();
        check(osc_run == 1'b1, "R7 osc runs on rail", int'(osc_run), 1);
        check(osc_freq == 6'd10, "R7 static freq", int'(osc_freq), 10);
        static_freq = 20;
        @(negedge clk); @(negedge clk);
        check(osc_freq == 6'd20, "R7 freq follows", int'(osc_freq), 20);

        // R2 software source: low -> high (R4)
        sw_freq = 33;
        expect_seq(2, 2 * SEG + 2, "R4 low to high");
        sw_rail = 2'd2; mode_sel = 2'd1;
        settle();
        check(osc_freq == 6'd33, "R2 software freq", int'(osc_freq), 33);

        // R5 / R2: rail code 3 disconnects
        expect_seq(0, SEG + 2, "R5 high to off");
        sw_rail = 2'd3;
        settle();
        repeat (4) @(negedge clk);
        check(!osc_run, "R5 osc stays off", int'(osc_run), 0);

        // R8: request changes mid-sequence
        expect_seq(1, SEG + 2, "R8 first sequence");
        expect_seq(2, 2 * SEG + 2, "R8 later request");
        sw_rail = 2'd1;
        repeat (4) @(negedge clk);
        sw_rail = 2'd2;
        settle();

        // R2: mode code 3 behaves as static (static_rail = low)
        expect_seq(1, 2 * SEG + 2, "R2 mode 3 static");
        mode_sel = 2'd3;
        settle();
        check(osc_freq == 6'd20, "R2 mode 3 static freq", int'(osc_freq), 20);

        // hardware mode: idle history has already asked for off (R12)
        expect_seq(0, SEG + 2, "R12 idle history off");
        mode_sel = 2'd2;
        settle();

        // R11 climb: wake to low, then above upper threshold to high
        expect_seq(1, SEG + 2, "R12 wake to low");
        expect_seq(2, 2 * SEG + 2, "R11 above upper threshold");
        fifo_level = 200;
        settle();
        check(osc_freq == 6'd50, "R11 high freq", int'(osc_freq), 50);

        // R11 hysteresis band: no change
        fifo_level = 70;
        repeat (12 * WIN) @(negedge clk);
        check(rail_state == 2'd2, "R11 held in band", int'(rail_state), 2);

        // R9 heavy stalls halve the sample, pulling below lower threshold
        expect_seq(1, 2 * SEG + 2, "R9 stall halved sample");
        core_stall = 1'b1;
        settle();
        check(osc_freq == 6'd5, "R11 low freq", int'(osc_freq), 5);

        // R12 idle run disconnects
        expect_seq(0, SEG + 2, "R12 idle windows");
        core_stall = 1'b0; fifo_level = 0;
        settle();
        check(!osc_run, "R12 osc off when idle", int'(osc_run), 0);

        // R12 nonzero sample wakes
        expect_seq(1, SEG + 2, "R12 wake");
        fifo_level = 60;
        settle();
        repeat (2 * WIN) @(negedge clk);
        check(rail_state == 2'd1, "R12 stays low", int'(rail_state), 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule